// File: doc/BRIEF.md
# Mixed-Width Dual-Port Memory

This block is a synchronous true dual-port memory over a single 4096-bit store. Each of its two ports has its own clock, enable, write enable, output clear, address, write data and read data. A port's data width is chosen at elaboration from 1, 2, 4, 8 or 16 bits, and the address width follows from it. Both ports see the same bits, so one port can write words of one width and the other can read them back at another width.

A port does nothing on an edge where its enable is inactive. With enable active it either writes (and shows the written value on its own read data on that edge) or reads the addressed word. An active output clear zeroes only that port's read data register and leaves the store alone. Every clock, enable, write enable and clear pin has its own polarity-inversion parameter. The store and both read registers start at zero.

Top module: `mwram_dp`

## Requirements
- R1: A port of width W has address width log2(4096/W) (12, 11, 10, 9 or 8 bits for W = 1, 2, 4, 8, 16), and every address from 0 to 4096/W-1 reaches its own word.
- R2: Word A on a port of width W holds store bits A*W (least significant) up to (A+1)*W-1 (most significant), whatever width the other port has, so data written by one port reads back at the other port's width from the same bit positions.
- R3: With enable active and write enable inactive, read data after the active edge equals the addressed word as stored at that edge.
- R4: With enable inactive, the edge changes no stored bit and read data keeps its previous value.
- R5: With enable and write enable active, write data is stored at the addressed word and read data shows the same write data after that edge.
- R6: With enable and clear active, read data becomes zero after the edge and no stored bit changes.
- R7: A clear on one port does not disturb a write made by the other port.
- R8: Each of the clock, enable, write enable and clear inputs of each port is active high (clock: rising edge) when its inversion parameter is 0 and active low (clock: falling edge) when it is 1.
- R9: When clear and write enable are both active with enable, the write is still stored and read data becomes zero.
- R10: At power-up every stored bit and both read data registers are zero.
- R11: The two ports run on unrelated clocks and operate correctly side by side when they touch disjoint bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A clock |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| rstA | input | 1 | Port A read data clear |
| addrA | input | log2(4096/WIDTH_A) | Port A word address |
| dinA | input | WIDTH_A | Port A write data |
| doutA | output | WIDTH_A | Port A read data |
| clkB | input | 1 | Port B clock |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| rstB | input | 1 | Port B read data clear |
| addrB | input | log2(4096/WIDTH_B) | Port B word address |
| dinB | input | WIDTH_B | Port B write data |
| doutB | output | WIDTH_B | Port B read data |

## Verification
A wrong bit in the store stays hidden until some port reads a word that covers it, and then shows one active edge after that read as a mismatched slice, which is why the bench sweeps every word at both widths after each full write pass. A bad read data register shows on the very next active edge of its own port: a value that moves while enable is off, a nonzero value after a clear, or a missing write-through. A fault in the shared bit mapping only shows when the two widths differ, so every sweep writes at one width and reads at the other.

// File: rtl/mwram_pkg.sv
`timescale 1ns/1ps
package mwram_pkg;

  // Total number of storage bits shared by both ports.
  localparam int ARRAY_BITS = 4096;

  // Per-port strobes handed from control to datapath.
  typedef struct packed {
    logic upd;   // enable active: read data register may change
    logic wr;    // store write data at the addressed word
    logic clr;   // force read data register to zero
  } portStrobe_t;

  function automatic bit legalWidth(int w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
  endfunction

endpackage

// File: rtl/mwram_ctrl.sv
`timescale 1ns/1ps
module mwram_ctrl
  import mwram_pkg::*;
#(
  parameter bit INV_EN  = 1'b0,
  parameter bit INV_WE  = 1'b0,
  parameter bit INV_RST = 1'b0
) (
  input  logic        enPin,
  input  logic        wePin,
  input  logic        rstPin,
  output portStrobe_t strobe
);

  logic enAct;
  logic weAct;
  logic rstAct;

  // Polarity folding: a set inversion bit makes the pin active low.
  assign enAct  = enPin  ^ INV_EN;
  assign weAct  = wePin  ^ INV_WE;
  assign rstAct = rstPin ^ INV_RST;

  // Enable gates every action of the port.
  always_comb begin
    strobe.upd = enAct;
    strobe.wr  = enAct & weAct;
    strobe.clr = enAct & rstAct;
  end

endmodule

// File: rtl/mwram_core.sv
`timescale 1ns/1ps
module mwram_core
  import mwram_pkg::*;
#(
  parameter int WIDTH_A    = 4,
  parameter int WIDTH_B    = 16,
  parameter int TOTAL_BITS = 4096,
  parameter int ADDR_A_W   = 10,
  parameter int ADDR_B_W   = 8
) (
  input  logic                clkA,
  input  portStrobe_t         strobeA,
  input  logic [ADDR_A_W-1:0] addrA,
  input  logic [WIDTH_A-1:0]  dinA,
  output logic [WIDTH_A-1:0]  doutA,
  input  logic                clkB,
  input  portStrobe_t         strobeB,
  input  logic [ADDR_B_W-1:0] addrB,
  input  logic [WIDTH_B-1:0]  dinB,
  output logic [WIDTH_B-1:0]  doutB
);

  localparam int IDX_W = $clog2(TOTAL_BITS);

  // Two banks, each written by one clock only; a bit's value is the XOR
  // of both banks, so either port can overwrite any bit.
  logic [TOTAL_BITS-1:0] bankA = '0;
  logic [TOTAL_BITS-1:0] bankB = '0;
  logic [WIDTH_A-1:0]    regA  = '0;
  logic [WIDTH_B-1:0]    regB  = '0;

  logic [IDX_W-1:0]   baseA;
  logic [IDX_W-1:0]   baseB;
  logic [WIDTH_A-1:0] wordAtA;
  logic [WIDTH_B-1:0] wordAtB;

  // Low bit of each word: address times port width.
  assign baseA = IDX_W'(addrA) * IDX_W'(WIDTH_A);
  assign baseB = IDX_W'(addrB) * IDX_W'(WIDTH_B);

  assign wordAtA = bankA[baseA +: WIDTH_A] ^ bankB[baseA +: WIDTH_A];
  assign wordAtB = bankA[baseB +: WIDTH_B] ^ bankB[baseB +: WIDTH_B];

  // Port A: store and read register.
  always_ff @(posedge clkA) begin
    if (strobeA.wr)
      bankA[baseA +: WIDTH_A] <= dinA ^ bankB[baseA +: WIDTH_A];
    if (strobeA.clr)
      regA <= '0;
    else if (strobeA.wr)
      regA <= dinA;
    else if (strobeA.upd)
      regA <= wordAtA;
  end

  // Port B: store and read register.
  always_ff @(posedge clkB) begin
    if (strobeB.wr)
      bankB[baseB +: WIDTH_B] <= dinB ^ bankA[baseB +: WIDTH_B];
    if (strobeB.clr)
      regB <= '0;
    else if (strobeB.wr)
      regB <= dinB;
    else if (strobeB.upd)
      regB <= wordAtB;
  end

  assign doutA = regA;
  assign doutB = regB;

  // Armed after the first edge of each clock so that $past is defined.
  logic armedA = 1'b0;
  logic armedB = 1'b0;
  always_ff @(posedge clkA) armedA <= 1'b1;
  always_ff @(posedge clkB) armedB <= 1'b1;

  AST_A_IDLE_HOLD: assert property (@(posedge clkA) disable iff (!armedA)
    !strobeA.upd |=> $stable(doutA)); // R4
  AST_B_IDLE_HOLD: assert property (@(posedge clkB) disable iff (!armedB)
    !strobeB.upd |=> $stable(doutB)); // R4
  AST_A_CLEAR_ZERO: assert property (@(posedge clkA) disable iff (!armedA)
    strobeA.clr |=> (doutA == '0)); // R6
  AST_B_CLEAR_ZERO: assert property (@(posedge clkB) disable iff (!armedB)
    strobeB.clr |=> (doutB == '0)); // R6
  AST_A_WRITE_THROUGH: assert property (@(posedge clkA) disable iff (!armedA)
    (strobeA.wr && !strobeA.clr) |=> (doutA == $past(dinA))); // R5
  AST_B_WRITE_THROUGH: assert property (@(posedge clkB) disable iff (!armedB)
    (strobeB.wr && !strobeB.clr) |=> (doutB == $past(dinB))); // R5

endmodule

// File: rtl/mwram_dp.sv
`timescale 1ns/1ps
module mwram_dp
  import mwram_pkg::*;
#(
  parameter int WIDTH_A   = 4,
  parameter int WIDTH_B   = 16,
  parameter bit INV_CLK_A = 1'b0,
  parameter bit INV_EN_A  = 1'b0,
  parameter bit INV_WE_A  = 1'b0,
  parameter bit INV_RST_A = 1'b0,
  parameter bit INV_CLK_B = 1'b0,
  parameter bit INV_EN_B  = 1'b0,
  parameter bit INV_WE_B  = 1'b0,
  parameter bit INV_RST_B = 1'b0,
  localparam int ADDR_A_W = $clog2(ARRAY_BITS / WIDTH_A),
  localparam int ADDR_B_W = $clog2(ARRAY_BITS / WIDTH_B)
) (
  input  logic                clkA,
  input  logic                enA,
  input  logic                weA,
  input  logic                rstA,
  input  logic [ADDR_A_W-1:0] addrA,
  input  logic [WIDTH_A-1:0]  dinA,
  output logic [WIDTH_A-1:0]  doutA,
  input  logic                clkB,
  input  logic                enB,
  input  logic                weB,
  input  logic                rstB,
  input  logic [ADDR_B_W-1:0] addrB,
  input  logic [WIDTH_B-1:0]  dinB,
  output logic [WIDTH_B-1:0]  doutB
);

  initial begin
    AST_LEGAL_WIDTH: assert (legalWidth(WIDTH_A) && legalWidth(WIDTH_B)); // R1
  end

  logic        clkAEff;
  logic        clkBEff;
  portStrobe_t strobeA;
  portStrobe_t strobeB;

  // Clock polarity option: inverted clock makes the falling edge active.
  assign clkAEff = clkA ^ INV_CLK_A;
  assign clkBEff = clkB ^ INV_CLK_B;

  mwram_ctrl #(
    .INV_EN (INV_EN_A),
    .INV_WE (INV_WE_A),
    .INV_RST(INV_RST_A)
  ) u_ctrlA (
    .enPin (enA),
    .wePin (weA),
    .rstPin(rstA),
    .strobe(strobeA)
  );

  mwram_ctrl #(
    .INV_EN (INV_EN_B),
    .INV_WE (INV_WE_B),
    .INV_RST(INV_RST_B)
  ) u_ctrlB (
    .enPin (enB),
    .wePin (weB),
    .rstPin(rstB),
    .strobe(strobeB)
  );

  mwram_core #(
    .WIDTH_A   (WIDTH_A),
    .WIDTH_B   (WIDTH_B),
    .TOTAL_BITS(ARRAY_BITS),
    .ADDR_A_W  (ADDR_A_W),
    .ADDR_B_W  (ADDR_B_W)
  ) u_core (
    .clkA   (clkAEff),
    .strobeA(strobeA),
    .addrA  (addrA),
    .dinA   (dinA),
    .doutA  (doutA),
    .clkB   (clkBEff),
    .strobeB(strobeB),
    .addrB  (addrB),
    .dinB   (dinB),
    .doutB  (doutB)
  );

endmodule

// File: tb/mwram_dp_bench.sv
`timescale 1ns/1ps
module mwram_dp_bench;

  // Port A: 4 bits x 1024, write enable active low (R8).
  // Port B: 16 bits x 256, falling clock, enable and clear active low (R8).
  logic       clkA = 1'b0;
  logic       clkB = 1'b0;
  logic       enA = 1'b0, weA = 1'b1, rstA = 1'b0;
  logic [9:0] addrA = '0;
  logic [3:0] dinA = '0;
  logic [3:0] doutA;
  logic       enB = 1'b1, weB = 1'b0, rstB = 1'b1;
  logic [7:0] addrB = '0;
  logic [15:0] dinB = '0;
  logic [15:0] doutB;

  always #10 clkA = ~clkA;   // 50 MHz
  always #13 clkB = ~clkB;   // unrelated second clock

  mwram_dp #(
    .WIDTH_A(4), .WIDTH_B(16),
    .INV_CLK_A(1'b0), .INV_EN_A(1'b0), .INV_WE_A(1'b1), .INV_RST_A(1'b0),
    .INV_CLK_B(1'b1), .INV_EN_B(1'b1), .INV_WE_B(1'b0), .INV_RST_B(1'b1)
  ) u_mwram_dp (
    .clkA(clkA), .enA(enA), .weA(weA), .rstA(rstA), .addrA(addrA), .dinA(dinA), .doutA(doutA),
    .clkB(clkB), .enB(enB), .weB(weB), .rstB(rstB), .addrB(addrB), .dinB(dinB), .doutB(doutB)
  );

  bit [4095:0] refMem = '0;
  logic [3:0]  expA = '0;
  logic [15:0] expB = '0;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One port A operation: drive after an edge, sample after the next active edge.
  task automatic accA(input bit en, input bit we, input bit rst, input int addr,
                      input logic [3:0] d, input string req);
    @(posedge clkA); #2;
    enA = en; weA = ~we; rstA = rst; addrA = addr[9:0]; dinA = d;
    @(posedge clkA); #2;
    if (en) begin
      if (we) refMem[addr*4 +: 4] = d;
      expA = rst ? 4'h0 : (we ? d : refMem[addr*4 +: 4]);
    end
    check(req, {12'h0, doutA}, {12'h0, expA});
    enA = 1'b0; weA = 1'b1; rstA = 1'b0;
  endtask

  // One port B operation on the falling edge with active-low pins.
  task automatic accB(input bit en, input bit we, input bit rst, input int addr,
                      input logic [15:0] d, input string req);
    @(negedge clkB); #2;
    enB = ~en; weB = we; rstB = ~rst; addrB = addr[7:0]; dinB = d;
    @(negedge clkB); #2;
    if (en) begin
      if (we) refMem[addr*16 +: 16] = d;
      expB = rst ? 16'h0 : (we ? d : refMem[addr*16 +: 16]);
    end
    check(req, doutB, expB);
    enB = 1'b1; weB = 1'b0; rstB = 1'b1;
  endtask

  initial begin
    #1;
    check("R10 power-up doutA", {12'h0, doutA}, 16'h0);
    check("R10 power-up doutB", doutB, 16'h0);
    accA(1, 0, 0, 5,   4'h0,  "R10 R3 read A fresh cell");
    accB(1, 0, 0, 200, 16'h0, "R10 R8 read B fresh cell");

    // Full B write pass, then every nibble read on A (R1, R2, R5).
    for (int a = 0; a < 256; a++)
      accB(1, 1, 0, a, 16'(a * 40503) ^ 16'h3C5A, "R5 R1 B write-through");
    for (int a = 0; a < 1024; a++)
      accA(1, 0, 0, a, 4'h0, "R2 R3 A reads B data");

    // Full A write pass, then every word read on B.
    for (int a = 0; a < 1024; a++)
      accA(1, 1, 0, a, 4'(a * 7 + 3), "R5 R1 A write-through");
    for (int a = 0; a < 256; a++)
      accB(1, 0, 0, a, 16'h0, "R2 R3 R8 B reads A data");

    // Enable inactive: no write, read data holds.
    accA(1, 0, 0, 7, 4'h0, "R3 A read before idle");
    accA(0, 1, 0, 7, 4'hF ^ refMem[31:28], "R4 A idle write holds dout");
    accA(1, 0, 0, 7, 4'h0, "R4 A idle write left cell");
    accB(1, 0, 0, 9, 16'h0, "R3 B read before idle");
    accB(0, 1, 1, 9, ~refMem[159:144], "R4 R8 B idle write and clear hold");
    accB(1, 0, 0, 9, 16'h0, "R4 R8 B idle write left cell");

    // Clear on read, then cell intact.
    accA(1, 0, 1, 3, 4'h0, "R6 A clear gives zero");
    accA(1, 0, 0, 3, 4'h0, "R6 A cell kept after clear");
    accB(1, 0, 1, 40, 16'h0, "R6 R8 B clear gives zero");
    accB(1, 0, 0, 40, 16'h0, "R6 B cell kept after clear");

    // Clear together with write.
    accA(1, 1, 1, 9, ~refMem[39:36], "R9 A clear with write");
    accA(1, 0, 0, 9, 4'h0, "R9 A write stored under clear");
    accB(1, 1, 1, 77, 16'hBEEF, "R9 B clear with write");
    accB(1, 0, 0, 77, 16'h0, "R9 B write stored under clear");

    // A keeps clearing while B writes (R7).
    fork
      for (int i = 0; i < 40; i++) accA(1, 0, 1, i, 4'h0, "R7 A clear while B writes");
      for (int i = 0; i < 30; i++) accB(1, 1, 0, 128 + i, 16'(i * 4099 + 17), "R7 B write during A clear");
    join
    for (int i = 0; i < 30; i++) accB(1, 0, 0, 128 + i, 16'h0, "R7 B write survived A clear");

    // Random side-by-side traffic on disjoint halves (R11).
    fork
      for (int i = 0; i < 300; i++)
        accA($urandom_range(3) != 0, $urandom_range(1) == 1, $urandom_range(7) == 0,
             $urandom_range(511), 4'($urandom), "R11 A random traffic");
      for (int i = 0; i < 300; i++)
        accB($urandom_range(3) != 0, $urandom_range(1) == 1, $urandom_range(7) == 0,
             $urandom_range(255, 128), 16'($urandom), "R11 B random traffic");
    join
    for (int a = 512; a < 1024; a += 5) accA(1, 0, 0, a, 4'h0, "R11 R2 A reads B half");
    for (int a = 0; a < 128; a += 3)    accB(1, 0, 0, a, 16'h0, "R11 R2 B reads A half");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule